// File: doc/BRIEF.md
# Transposed-Form Fixed-Point FIR Filter

This block is an N-tap finite impulse response filter built in transposed direct form. It accepts one signed fractional sample on every clock in which filtering is enabled and returns one filtered sample per clock. Every tap has its own multiplier. Each product is rounded to the output precision. The partial sums then move through a chain of registers, with one adder between neighbouring registers. As a result, the longest combinational path is one multiply followed by one add, whatever the tap count.

The tap weights are held in a chain of registers and are shifted in serially before filtering starts. To load them, the user drops the mode input to load mode and pulses the load-start input for one cycle. The user then presents the weights one per clock, lowest index first. The block raises a one-cycle done flag after the last weight. Once the mode input is raised, the filter runs with those weights. Two separate synchronous resets are provided. One clears the arithmetic pipeline. The other clears the weight chain.

Top module: `fir_transposed`

## Requirements
- R1: With filtering enabled, the output register captures y(n) = sum over k of round(h_k * x(n-k)) on the same edge that captures x(n). An impulse of value 0.5 therefore returns the codes of h0, h1, ..., h(N-1) on successive cycles, with h0 appearing first.
- R2: Samples are two's-complement with 1 integer bit and M fraction bits. Weights use 1 integer bit and L fraction bits. The output uses 1 integer bit and K fraction bits. A product is formed at full width with M+L fraction bits.
- R3: Each product is reduced to K fraction bits as follows. The low M+L-K bits are discarded. The most significant discarded bit is then added at the lowest kept bit. So +0.5 LSB rounds to +1 LSB, and -0.5 LSB rounds to 0.
- R4: All additions use K+1 bits and wrap modulo 2^(K+1). Sums that exceed the output range wrap around and do not saturate.
- R5: With the mode input low (load mode), a cycle in which load_start is high begins a load. On each of the next N cycles, coef_in is shifted into the chain. The first value shifted in becomes h0.
- R6: load_done is high for exactly one cycle. That cycle immediately follows the cycle in which the N-th weight was sampled, and load_done is low at every other time.
- R7: Outside a load sequence, coef_in has no effect on the stored weights.
- R8: rst_data clears the delay registers and the output to zero. It leaves the weight chain unchanged.
- R9: rst_coef clears every weight to zero and cancels any load in progress. It does not touch the delay registers or the output.
- R10: While the mode input is low, the delay registers and the output hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_data | input | 1 | Synchronous active-high reset of the delay registers and the output |
| rst_coef | input | 1 | Synchronous active-high reset of the weight chain and the load sequencer |
| run_mode | input | 1 | 0 = load weights, 1 = filter |
| load_start | input | 1 | Single-cycle request to begin a weight load (load mode only) |
| coef_in | input | L+1 | Serial weight input, 1.L two's complement |
| load_done | output | 1 | One-cycle pulse after the last weight is shifted in |
| x_in | input | M+1 | Sample input, 1.M two's complement |
| y_out | output | K+1 | Registered filtered output, 1.K two's complement |

## Verification
The assertions check several properties on every clock. They confirm that the done flag never lasts longer than one cycle and only ever follows a shift. They confirm that a pipeline reset leaves the output at zero and does not disturb the weights. They also confirm that the output freezes in load mode. Whether the arithmetic is correct can only be shown by the bench's scenarios. These are impulse responses that reveal the tap order, a product that lands exactly on a half LSB of either sign, a sum that wraps past full scale, and weight values driven on coef_in outside a load that must leave no trace.

// File: rtl/fir_pkg.sv
package fir_pkg;
  typedef enum logic [0:0] {
    LD_IDLE  = 1'b0,
    LD_SHIFT = 1'b1
  } load_state_t;
endpackage

// File: rtl/fir_load_ctrl.sv
module fir_load_ctrl #(
  parameter int TAPS = 8
) (
  input  logic clk,
  input  logic rst_coef,
  input  logic run_mode,
  input  logic load_start,
  output logic shift_en,
  output logic load_done
);
  import fir_pkg::*;

  localparam int CNT_W = (TAPS > 1) ? $clog2(TAPS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TAPS - 1);

  load_state_t       state;
  logic [CNT_W-1:0]  cnt;

  always_ff @(posedge clk) begin
    if (rst_coef) begin
      state     <= LD_IDLE;
      cnt       <= '0;
      load_done <= 1'b0;
    end else begin
      load_done <= 1'b0;
      case (state)
        LD_IDLE: begin
          if (!run_mode && load_start) begin
            state <= LD_SHIFT;
            cnt   <= '0;
          end
        end
        default: begin
          if (run_mode) begin
            state <= LD_IDLE;
          end else if (cnt == LAST) begin
            state     <= LD_IDLE;
            load_done <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end

  assign shift_en = (state == LD_SHIFT) && !run_mode;

  // R6: the done flag is a single-cycle pulse
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst_coef)
    load_done |=> !load_done);

  // R6: done is only raised right after a weight was shifted in
  a_r6_done_after_shift: assert property (@(posedge clk) disable iff (rst_coef)
    $rose(load_done) |-> $past(shift_en));
endmodule

// File: rtl/fir_coef_chain.sv
module fir_coef_chain #(
  parameter int TAPS   = 8,
  parameter int COEF_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_coef,
  input  logic                          shift_en,
  input  logic [COEF_W-1:0]             coef_in,
  output logic [TAPS-1:0][COEF_W-1:0]   coef_q
);
  // Entry at the top index; after TAPS shifts the first value sits at index 0,
  // which feeds the multiplier next to the output register.
  always_ff @(posedge clk) begin
    if (rst_coef) begin
      coef_q <= '0;
    end else if (shift_en) begin
      coef_q[TAPS-1] <= coef_in;
      for (int i = 0; i < TAPS - 1; i++) begin
        coef_q[i] <= coef_q[i+1];
      end
    end
  end
endmodule

// File: rtl/fir_tap_mul.sv
module fir_tap_mul #(
  parameter int IN_FRAC   = 8,
  parameter int COEF_FRAC = 7,
  parameter int OUT_FRAC  = 8
) (
  input  logic [IN_FRAC:0]   x,
  input  logic [COEF_FRAC:0] h,
  output logic [OUT_FRAC:0]  p
);
  localparam int XW = IN_FRAC + 1;
  localparam int HW = COEF_FRAC + 1;
  localparam int FW = XW + HW;
  localparam int YW = OUT_FRAC + 1;
  localparam int SH = IN_FRAC + COEF_FRAC - OUT_FRAC;

  logic signed [FW-1:0] full;
  logic signed [FW-1:0] kept;
  logic                 half_bit;

  always_comb begin
    full     = FW'($signed(x)) * FW'($signed(h));
    kept     = full >>> SH;
    half_bit = full[SH-1];
    p        = kept[YW-1:0] + YW'(half_bit);
  end

  initial begin
    a_r3_shift_positive: assert (SH >= 1);
  end
endmodule

// File: rtl/fir_transposed.sv
module fir_transposed #(
  parameter int TAPS      = 8,
  parameter int IN_FRAC   = 8,
  parameter int OUT_FRAC  = 8,
  parameter int COEF_FRAC = 7
) (
  input  logic                 clk,
  input  logic                 rst_data,
  input  logic                 rst_coef,
  input  logic                 run_mode,
  input  logic                 load_start,
  input  logic [COEF_FRAC:0]   coef_in,
  output logic                 load_done,
  input  logic [IN_FRAC:0]     x_in,
  output logic [OUT_FRAC:0]    y_out
);
  localparam int HW = COEF_FRAC + 1;
  localparam int YW = OUT_FRAC + 1;

  logic                      shift_en;
  logic [TAPS-1:0][HW-1:0]   coef_q;
  logic [YW-1:0]             prod [TAPS];
  logic [YW-1:0]             acc  [1:TAPS-1];

  fir_load_ctrl #(.TAPS(TAPS)) u_ctrl (
    .clk        (clk),
    .rst_coef   (rst_coef),
    .run_mode   (run_mode),
    .load_start (load_start),
    .shift_en   (shift_en),
    .load_done  (load_done)
  );

  fir_coef_chain #(.TAPS(TAPS), .COEF_W(HW)) u_chain (
    .clk      (clk),
    .rst_coef (rst_coef),
    .shift_en (shift_en),
    .coef_in  (coef_in),
    .coef_q   (coef_q)
  );

  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    fir_tap_mul #(
      .IN_FRAC   (IN_FRAC),
      .COEF_FRAC (COEF_FRAC),
      .OUT_FRAC  (OUT_FRAC)
    ) u_mul (
      .x (x_in),
      .h (coef_q[k]),
      .p (prod[k])
    );
  end

  // Transposed chain: each register takes its product plus its upstream neighbour,
  // all sums in K+1 bits with wrap-around.
  always_ff @(posedge clk) begin
    if (rst_data) begin
      for (int k = 1; k < TAPS; k++) acc[k] <= '0;
      y_out <= '0;
    end else if (run_mode) begin
      acc[TAPS-1] <= prod[TAPS-1];
      for (int k = 1; k < TAPS - 1; k++) acc[k] <= prod[k] + acc[k+1];
      y_out <= prod[0] + acc[1];
    end
  end

  // R8: a pipeline reset leaves the output at zero
  a_r8_out_cleared: assert property (@(posedge clk)
    rst_data |=> (y_out == '0));

  // R10: load mode freezes the output
  a_r10_hold: assert property (@(posedge clk) disable iff (rst_data)
    (!run_mode && !$isunknown(y_out)) |=> $stable(y_out));

  // R8: a pipeline reset does not disturb the weights
  a_r8_coef_kept: assert property (@(posedge clk) disable iff (rst_coef)
    (rst_data && !shift_en) |=> $stable(coef_q));
endmodule

// File: tb/fir_transposed_test.sv
module fir_transposed_test;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam int M  = 8;
  localparam int K  = 8;
  localparam int L  = 7;
  localparam int SH = M + L - K;

  typedef struct packed {
    logic signed [M:0] x;
    logic signed [K:0] y;
  } vec_t;

  // Impulse of +0.5 then -0.5 with weights {10,-20,30,-40,50,60,-70,5}
  localparam vec_t VECS [16] = '{
    '{ 9'sd128, 9'sd10 }, '{ 9'sd0, -9'sd20 }, '{ 9'sd0, 9'sd30 }, '{ 9'sd0, -9'sd40 },
    '{ 9'sd0, 9'sd50 },   '{ 9'sd0, 9'sd60 },  '{ 9'sd0, -9'sd70 }, '{ 9'sd0, 9'sd5 },
    '{ -9'sd128, -9'sd10 }, '{ 9'sd0, 9'sd20 }, '{ 9'sd0, -9'sd30 }, '{ 9'sd0, 9'sd40 },
    '{ 9'sd0, -9'sd50 },  '{ 9'sd0, -9'sd60 }, '{ 9'sd0, 9'sd70 },  '{ 9'sd0, -9'sd5 }
  };

  logic clk = 1'b0;
  logic rst_data, rst_coef, run_mode, load_start, load_done;
  logic [L:0] coef_in;
  logic [M:0] x_in;
  logic [K:0] y_out;

  int checks = 0;
  int fails  = 0;
  int hm [N];
  int xh [N];

  always #(CLK_PERIOD/2) clk = ~clk;

  fir_transposed #(.TAPS(N), .IN_FRAC(M), .OUT_FRAC(K), .COEF_FRAC(L)) uut (
    .clk(clk), .rst_data(rst_data), .rst_coef(rst_coef), .run_mode(run_mode),
    .load_start(load_start), .coef_in(coef_in), .load_done(load_done),
    .x_in(x_in), .y_out(y_out)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int rnd(input int p);
    return (p >>> SH) + ((p >>> (SH - 1)) & 1);
  endfunction

  function automatic int model();
    int s = 0;
    for (int k = 0; k < N; k++) s += rnd(xh[k] * hm[k]);
    s = ((s % 512) + 512) % 512;
    return (s >= 256) ? s - 512 : s;
  endfunction

  task automatic clear_hist();
    for (int k = 0; k < N; k++) xh[k] = 0;
  endtask

  // Drive at a falling edge, sample at the next falling edge
  task automatic step(input int v);
    for (int k = N - 1; k > 0; k--) xh[k] = xh[k-1];
    xh[0] = v;
    x_in = (M+1)'(v);
    @(negedge clk);
  endtask

  task automatic load(input int w [N], input string req);
    run_mode = 1'b0;
    load_start = 1'b1;
    @(negedge clk);
    load_start = 1'b0;
    for (int k = 0; k < N; k++) begin
      coef_in = (L+1)'(w[k]);
      hm[k] = w[k];
      @(negedge clk);
      if (k < N - 1) check({req, " R6 done early"}, int'(load_done), 0);
    end
    check({req, " R6 done pulse"}, int'(load_done), 1);
    coef_in = '0;
    @(negedge clk);
    check({req, " R6 done drops"}, int'(load_done), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int w1 [N] = '{10, -20, 30, -40, 50, 60, -70, 5};
    int wmax [N] = '{127, 127, 127, 127, 127, 127, 127, 127};
    int wh [N] = '{64, 0, 0, 0, 0, 0, 0, 0};
    int seq [12] = '{37, -201, 255, -256, 3, 99, -1, 128, -77, 200, 15, -130};
    int held;
    rst_data = 1'b1; rst_coef = 1'b1; run_mode = 1'b0; load_start = 1'b0;
    coef_in = '0; x_in = '0;
    clear_hist();
    for (int k = 0; k < N; k++) hm[k] = 0;
    repeat (3) @(negedge clk);
    check("R8 reset output", int'($signed(y_out)), 0);
    check("R6 reset done", int'(load_done), 0);
    rst_data = 1'b0; rst_coef = 1'b0;
    @(negedge clk);

    // R5/R6: serial load, lowest index first
    load(w1, "R5");
    run_mode = 1'b1;
    for (int i = 0; i < 16; i++) begin
      step(int'(VECS[i].x));
      check($sformatf("R1 R2 vector %0d", i), int'($signed(y_out)), int'(VECS[i].y));
    end

    // R7: coef_in toggled outside a load sequence, in both modes
    run_mode = 1'b0;
    for (int i = 0; i < 4; i++) begin coef_in = 8'h7f; @(negedge clk); end
    run_mode = 1'b1;
    for (int i = 0; i < 4; i++) begin coef_in = 8'h55; step(0); end
    coef_in = '0;
    clear_hist();
    step(128);
    check("R7 h0 kept", int'($signed(y_out)), 10);
    step(0);
    check("R7 h1 kept", int'($signed(y_out)), -20);

    // R10: load mode holds the pipeline
    run_mode = 1'b0;
    held = int'($signed(y_out));
    x_in = 9'd77;
    repeat (3) @(negedge clk);
    check("R10 output held", int'($signed(y_out)), held);
    run_mode = 1'b1;
    step(0);
    check("R10 resumes with h2", int'($signed(y_out)), 30);

    // R8: pipeline reset clears sums, keeps weights
    rst_data = 1'b1; @(negedge clk); rst_data = 1'b0;
    check("R8 output cleared", int'($signed(y_out)), 0);
    clear_hist();
    step(0);
    check("R8 no residue", int'($signed(y_out)), 0);
    step(128);
    check("R8 weights kept", int'($signed(y_out)), 10);

    // R1/R3: arbitrary sequence against the model
    clear_hist();
    rst_data = 1'b1; @(negedge clk); rst_data = 1'b0;
    foreach (seq[i]) begin
      step(seq[i]);
      check($sformatf("R1 R3 sequence %0d", i), int'($signed(y_out)), model());
    end

    // R3: half LSB of either sign
    load(wh, "R3 load");
    run_mode = 1'b1;
    rst_data = 1'b1; @(negedge clk); rst_data = 1'b0;
    clear_hist();
    step(1);
    check("R3 +half rounds up", int'($signed(y_out)), 1);
    rst_data = 1'b1; @(negedge clk); rst_data = 1'b0;
    step(-1);
    check("R3 -half rounds to zero", int'($signed(y_out)), 0);

    // R4: wrap-around of a sum beyond full scale
    load(wmax, "R4 load");
    run_mode = 1'b1;
    rst_data = 1'b1; @(negedge clk); rst_data = 1'b0;
    clear_hist();
    for (int i = 0; i < N; i++) step(255);
    check("R4 wrapped sum", int'($signed(y_out)), -24);
    check("R4 model agrees", int'($signed(y_out)), model());

    // R9: coefficient reset clears weights only
    run_mode = 1'b0;
    held = int'($signed(y_out));
    rst_coef = 1'b1; @(negedge clk); rst_coef = 1'b0;
    check("R9 output untouched", int'($signed(y_out)), held);
    run_mode = 1'b1;
    for (int i = 0; i < N; i++) step(255);
    check("R9 weights zero", int'($signed(y_out)), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule